// File: doc/BRIEF.md
# Dithered Five-Bit Pulse Modulator Bank

This block drives five output pins, each from its own pulse modulator. The modulators share one clock prescaler and one cycle/frame timebase. Each channel takes an 8-bit setting. The upper five bits set the main pulse width within a 32-slot cycle. The lower three bits act as a binary rate multiplier: they lengthen the pulse by one slot in selected cycles of an 8-cycle frame. Averaged over a frame, this gives 8-bit resolution at the repetition rate of a 5-bit modulator. When a channel is not enabled, its pin carries the ordinary port bit instead.

A slot is one modulator clock. Its length is 2^(sel+1) input clocks, where sel is the 2-bit divider select. The settings, the enables and the divider select are all captured only at a frame boundary. Changes made in the middle of a frame therefore cannot shorten or glitch a pulse.

Each channel runs a three-state machine, advanced on every slot tick:
- PH_LOW is the idle state.
- PH_MAIN is the main high phase.
- PH_EXTRA is the one-slot inserted pulse.

On the first slot of every cycle the machine restarts:
- To PH_MAIN if the width is nonzero.
- Otherwise to PH_EXTRA if the cycle is selected for insertion.
- Otherwise to PH_LOW.

Later in the cycle:
- PH_MAIN leaves when the slot index reaches the width. It goes to PH_EXTRA if the cycle is selected and to PH_LOW otherwise.
- PH_EXTRA always moves to PH_LOW on the next tick.
- PH_LOW stays put until the cycle restarts.

The pin is high in PH_MAIN and in PH_EXTRA.

Top module: `dither_pwm_bank`

## Requirements
- R1: During reset and up to the first frame boundary after reset, every pin equals its port bit. Stored settings reset to 00h, enables reset to 0 and the divider select resets to 0. The first frame after reset therefore uses a divide-by-2 slot and ends 512 input clocks after reset release.
- R2: One slot lasts 2^(sel+1) input clocks for sel = 0..3, giving division by 2, 4, 8 or 16.
- R3: A cycle is 32 slots. An enabled pin is high from the start of the cycle for W slots and then low, where W is setting bits 7:3.
- R4: Setting bit 2 stretches cycles 1, 3, 5 and 7 of the frame (cycles counted 0..7). Bit 1 stretches cycles 2 and 6. Bit 0 stretches cycle 4. A stretched cycle is high for W+1 slots. Cycle 0 is never stretched.
- R5: With W = 0, a stretched cycle carries a single one-slot pulse. With W = 31, a stretched cycle is high for all 32 slots.
- R6: Setting 83h gives 16 high slots per cycle, with 3 of the 8 cycles stretched, for 131 high slots per frame.
- R7: Settings, enables and divider select take effect only at a frame boundary. Changes made within a frame do not alter that frame's output.
- R8: A channel whose captured enable is 0 passes its port bit to its pin combinationally, with no clock delay.
- R9: Each channel's output depends only on its own setting and enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 2 | Slot divider select, slot = 2^(div_sel+1) clocks |
| ch_en | input | 5 | Per-channel modulator enable |
| ch_data | input | 40 | Channel settings, channel i in bits 8i+7:8i |
| port_bits | input | 5 | Ordinary port bits used when a channel is disabled |
| pin_out | output | 5 | Pin signals |

## Verification
The assertions take the inputs to be arbitrary at every clock, with no hold-time requirement. This is because capture happens only at a frame boundary, and within a frame the machine relies on nothing but its own captured copy. They rely on the slot tick never firing on two consecutive clocks. Capture and the slot tick coincide, which keeps the captured setting stable between ticks. The stimulus changes settings, enables and divider select right after each frame boundary, in the middle of the frame that uses the previous values. The assertions therefore see unaligned input changes, while the expected waveforms stay defined frame by frame.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    typedef enum logic [1:0] {
        PH_LOW   = 2'd0,
        PH_MAIN  = 2'd1,
        PH_EXTRA = 2'd2
    } phase_t;
endpackage

// File: rtl/dpwm_prescale.sv
module dpwm_prescale #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 2 ** SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             load,
    output logic             tick
);
    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    logic [SEL_W-1:0] div_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   lim;

    always_comb begin
        lim  = (ONE << ({1'b0, div_q} + 1'b1)) - ONE;
        tick = ({1'b0, cnt} >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (load) begin
                div_q <= div_sel;
            end
        end
    end

    // R2: a slot is at least two input clocks long
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("tick on consecutive clocks");
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
    parameter int SLOT_W = 5,
    parameter int CYC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] nslot,
    output logic [CYC_W-1:0]  ncyc,
    output logic              wrap
);
    logic [CYC_W-1:0] cyc;
    logic             slot_last;

    always_comb begin
        slot_last = (slot == {SLOT_W{1'b1}});
        nslot     = slot + 1'b1;
        ncyc      = slot_last ? cyc + 1'b1 : cyc;
        wrap      = tick && slot_last && (cyc == {CYC_W{1'b1}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
            cyc  <= '0;
        end else if (tick) begin
            slot <= nslot;
            cyc  <= ncyc;
        end
    end

    // R3: the slot index moves only on a modulator tick
    assert_slot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slot)) else $error("slot moved without tick");
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
    import dpwm_pkg::*;
#(
    parameter int SLOT_W = 5,
    parameter int BRM_W  = 3,
    parameter int DATA_W = SLOT_W + BRM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wrap,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W-1:0] nslot,
    input  logic [BRM_W-1:0]  ncyc,
    input  logic [DATA_W-1:0] data_in,
    input  logic              en_in,
    input  logic              port_bit,
    output logic              pin
);
    logic [DATA_W-1:0] data_q;
    logic              en_q;
    logic [DATA_W-1:0] eff;
    logic [SLOT_W-1:0] width;
    logic [BRM_W-1:0]  brm;
    logic              ins;
    logic              pwm;
    phase_t            st, nst;

    // rate multiplier: brm bit k picks the cycles whose lowest set bit is BRM_W-1-k
    function automatic logic pick(input logic [BRM_W-1:0] c, input logic [BRM_W-1:0] b);
        logic r;
        logic [BRM_W-1:0] below;
        r = 1'b0;
        for (int k = 0; k < BRM_W; k++) begin
            below = (BRM_W'(1) << (BRM_W-1-k)) - BRM_W'(1);
            if (b[k] && c[BRM_W-1-k] && ((c & below) == '0)) begin
                r = 1'b1;
            end
        end
        return r;
    endfunction

    always_comb begin
        eff   = wrap ? data_in : data_q;
        width = eff[DATA_W-1:BRM_W];
        brm   = eff[BRM_W-1:0];
        ins   = pick(ncyc, brm);
    end

    // next-state process
    always_comb begin
        nst = st;
        if (nslot == '0) begin
            if (width != '0)   nst = PH_MAIN;
            else if (ins)      nst = PH_EXTRA;
            else               nst = PH_LOW;
        end else begin
            unique case (st)
                PH_MAIN:  if (nslot == width) nst = ins ? PH_EXTRA : PH_LOW;
                PH_EXTRA: nst = PH_LOW;
                PH_LOW:   nst = PH_LOW;
                default:  nst = PH_LOW;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= PH_LOW;
            data_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (tick) begin
                st <= nst;
            end
            if (wrap) begin
                data_q <= data_in;
                en_q   <= en_in;
            end
        end
    end

    // output process
    always_comb begin
        unique case (st)
            PH_MAIN, PH_EXTRA: pwm = 1'b1;
            default:           pwm = 1'b0;
        endcase
        pin = en_q ? pwm : port_bit;
    end

    // R3: the main phase lies inside the programmed width
    assert_main_in_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_MAIN) |-> (slot < data_q[DATA_W-1:BRM_W])) else $error("main phase past width");

    // R4: the inserted pulse sits right after the width
    assert_extra_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_EXTRA) |-> (slot == data_q[DATA_W-1:BRM_W])) else $error("extra pulse misplaced");

    // R4: the inserted pulse lasts one slot
    assert_extra_one_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_EXTRA && tick) |=> (st != PH_EXTRA)) else $error("extra pulse too long");

    // R7: captured settings change only at a frame boundary
    assert_frame_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(data_q) && $stable(en_q))) else $error("capture mid-frame");
endmodule

// File: rtl/dither_pwm_bank.sv
module dither_pwm_bank #(
    parameter int NUM_CH = 5,
    parameter int SLOT_W = 5,
    parameter int BRM_W  = 3,
    parameter int SEL_W  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SEL_W-1:0]            div_sel,
    input  logic [NUM_CH-1:0]           ch_en,
    input  logic [NUM_CH*(SLOT_W+BRM_W)-1:0] ch_data,
    input  logic [NUM_CH-1:0]           port_bits,
    output logic [NUM_CH-1:0]           pin_out
);
    localparam int DATA_W = SLOT_W + BRM_W;
    localparam int CNT_W  = 2 ** SEL_W;

    logic              tick;
    logic              wrap;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] nslot;
    logic [BRM_W-1:0]  ncyc;

    dpwm_prescale #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .load(wrap), .tick(tick)
    );

    dpwm_timebase #(.SLOT_W(SLOT_W), .CYC_W(BRM_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick), .slot(slot),
        .nslot(nslot), .ncyc(ncyc), .wrap(wrap)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dpwm_channel #(.SLOT_W(SLOT_W), .BRM_W(BRM_W), .DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap),
            .slot(slot), .nslot(nslot), .ncyc(ncyc),
            .data_in(ch_data[i*DATA_W +: DATA_W]), .en_in(ch_en[i]),
            .port_bit(port_bits[i]), .pin(pin_out[i])
        );
    end
endmodule

// File: tb/test_dither_pwm_bank.sv
module test_dither_pwm_bank;
    typedef struct packed {
        logic [1:0]  div;
        logic [4:0]  en;
        logic [39:0] data;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 5'b11111, 40'h10_07_FF_00_83},
        '{2'd1, 5'b10110, 40'h3C_83_01_F8_5A},
        '{2'd3, 5'b11111, 40'h80_FB_01_02_04},
        '{2'd2, 5'b01011, 40'hE6_18_C3_A5_7F},
        '{2'd1, 5'b11111, 40'hAB_F9_08_00_FF},
        '{2'd0, 5'b00000, 40'h55_55_55_55_55}
    };
    localparam logic [4:0] PORT_FIX = 5'b01101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  div_sel;
    logic [4:0]  ch_en;
    logic [39:0] ch_data;
    logic [4:0]  port_bits;
    logic [4:0]  pin_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dither_pwm_bank i_dither_pwm_bank (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .ch_en(ch_en),
        .ch_data(ch_data), .port_bits(port_bits), .pin_out(pin_out)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        div_sel = v.div;
        ch_en   = v.en;
        ch_data = v.data;
    endtask

    // R4 mapping of rate-multiplier bits to cycles
    function automatic int stretched(input logic [2:0] brm, input int c);
        stretched = ((brm[2] && (c % 2 == 1)) || (brm[1] && (c == 2 || c == 6)) ||
                     (brm[0] && c == 4)) ? 1 : 0;
    endfunction

    task automatic run_frame(input vec_t cur, input vec_t nxt);
        int d;
        int hi_tot [5];
        d = 2 << cur.div;
        for (int ch = 0; ch < 5; ch++) hi_tot[ch] = 0;
        for (int c = 0; c < 8; c++) begin
            int first_bad [5];
            int hi [5];
            for (int ch = 0; ch < 5; ch++) begin
                first_bad[ch] = -1;
                hi[ch] = 0;
            end
            for (int s = 0; s < 32 * d; s++) begin
                step();
                if (c == 0 && s == 0) drive(nxt);
                for (int ch = 0; ch < 5; ch++) begin
                    logic [7:0] byt;
                    int hw;
                    logic e;
                    byt = cur.data[ch*8 +: 8];
                    hw  = int'(byt[7:3]) + stretched(byt[2:0], c);
                    e   = cur.en[ch] ? (s < d * hw) : PORT_FIX[ch];
                    if (pin_out[ch]) begin
                        hi[ch]++;
                        hi_tot[ch]++;
                    end
                    if (pin_out[ch] !== e && first_bad[ch] < 0) first_bad[ch] = s;
                end
            end
            for (int ch = 0; ch < 5; ch++) begin
                logic [7:0] byt;
                int hw;
                byt = cur.data[ch*8 +: 8];
                hw  = cur.en[ch] ? d * (int'(byt[7:3]) + stretched(byt[2:0], c))
                                 : (PORT_FIX[ch] ? 32 * d : 0);
                check(first_bad[ch] < 0,
                      $sformatf("R2 R3 R4 R5 R7 R9 ch%0d cycle%0d div%0d data=%02h high slots", ch, c, cur.div, byt),
                      hi[ch], hw);
            end
        end
        for (int ch = 0; ch < 5; ch++) begin
            if (cur.en[ch] && cur.data[ch*8 +: 8] == 8'h83)
                check(hi_tot[ch] == 131 * d, $sformatf("R6 ch%0d frame high clocks", ch), hi_tot[ch], 131 * d);
        end
    endtask

    initial begin
        int mism;
        drive(VECS[0]);
        port_bits = PORT_FIX;
        #1;
        check(pin_out === PORT_FIX, "R1 pins follow port in reset", int'(pin_out), int'(PORT_FIX));
        @(negedge clk);
        port_bits = 5'b10010;
        #1;
        check(pin_out === 5'b10010, "R1 port change in reset", int'(pin_out), 18);
        port_bits = PORT_FIX;
        @(negedge clk);
        rst_n = 1'b1;
        mism = 0;
        for (int e = 1; e < 512; e++) begin
            step();
            if (pin_out !== PORT_FIX) mism++;
        end
        check(mism == 0, "R1 R7 first frame after reset uses port bits", mism, 0);

        for (int k = 0; k < NV; k++) begin
            run_frame(VECS[k], VECS[(k + 1 < NV) ? k + 1 : NV - 1]);
        end

        // now all channels disabled: port bits pass with no clock delay
        for (int p = 0; p < 4; p++) begin
            logic [4:0] pv;
            pv = 5'(7 * p + 3);
            port_bits = pv;
            #1;
            check(pin_out === pv, "R8 disabled pin follows port", int'(pin_out), int'(pv));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule